// File: doc/BRIEF.md
# Row/Column Selected Byte Memory with Gated Read

A sixteen-location, eight-bit-wide storage block. Its storage is a grid of single-bit cells. The upper half of the address picks one of four row lines, and the lower half picks one of four column lines. A cell takes new data only where its row line, its column line and the write enable meet. A cell puts its bit onto the shared read bus only where its row line, its column line and the read enable meet.

Writes are synchronous. On a rising clock edge with the write enable high, the write byte lands at the current address. Reads are combinational. While the read enable is high, the byte at the current address appears on the output. While the read enable is low, the output is held at zero. A synchronous active-high reset clears every location. The block suits small register files or scratch tables where an idle read bus must show zero and not stale data.

Top module: `ram_grid16x8`

## Requirements
- R1: The 4-bit address selects one of 16 independent byte locations: address bits [3:2] choose the row and bits [1:0] choose the column.
- R2: While rd_en is low, rdata is all zeros, including in the cycle straight after a write.
- R3: While rd_en is high, rdata combinationally shows the byte stored at the current address.
- R4: At a rising clock edge with wr_en high and rst low, wdata is stored at the current address and can be read from the next cycle on.
- R5: At an edge with wr_en low, no location changes, whatever wdata and addr carry.
- R6: A write changes only the addressed location. All 15 other locations keep their contents.
- R7: At a rising edge with rst high, every location is cleared to zero. Reset takes priority over a write at the same edge.
- R8: When rd_en and wr_en are both high at the same address, rdata shows the value stored before that cycle's write.
- R9: A stored byte is kept after wr_en falls and after wdata changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset are taken on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all locations |
| addr | input | 4 | Location select: row in [3:2], column in [1:0] |
| wdata | input | 8 | Byte to store |
| wr_en | input | 1 | Write enable, sampled at the clock edge |
| rd_en | input | 1 | Read enable; gates rdata to zero when low |
| rdata | output | 8 | Addressed byte while rd_en is high, otherwise zero |

## Verification
The bench builds the block with its default parameters: two row bits, two column bits and eight data bits. That is small enough to fill every one of the 16 locations with a distinct byte and read each back, so decode aliasing between rows and columns shows up directly. The same size lets the bench issue a reset in the middle of a run and then sweep the whole array to confirm it is empty. A behavioural model checks every cycle, including read-during-write on the same address and write pulses with read gated off.

// File: rtl/ramgrid_pkg.sv
package ramgrid_pkg;

    localparam int DEF_ROW_BITS = 2;
    localparam int DEF_COL_BITS = 2;
    localparam int DEF_DATA_W   = 8;

    // enable pair carried from the top into the cell grid
    typedef struct packed {
        logic wr;
        logic rd;
    } port_ctl_t;

    function automatic port_ctl_t make_ctl(input logic wr, input logic rd);
        port_ctl_t c;
        c.wr = wr;
        c.rd = rd;
        return c;
    endfunction

endpackage

// File: rtl/rg_decoder.sv
module rg_decoder #(
    parameter int SEL_BITS = 2,
    localparam int LINES   = 1 << SEL_BITS
) (
    input  logic [SEL_BITS-1:0] sel,
    output logic [LINES-1:0]    line
);

    always_comb begin
        line = '0;
        for (int i = 0; i < LINES; i++) begin
            if (sel == SEL_BITS'(i)) line[i] = 1'b1;
        end
    end

endmodule

// File: rtl/rg_bitcell.sv
module rg_bitcell (
    input  logic clk,
    input  logic rst,
    input  logic row,
    input  logic col,
    input  ramgrid_pkg::port_ctl_t ctl,
    input  logic d,
    output logic q
);

    logic stored;
    logic hit;

    assign hit = row & col;

    always_ff @(posedge clk) begin
        if (rst)
            stored <= 1'b0;
        else if (hit && ctl.wr)
            stored <= d;
    end

    assign q = hit & ctl.rd & stored;

    // R5/R6: an unselected or non-writing cell holds its bit
    a_r5_cell_hold: assert property (@(posedge clk) disable iff (rst)
        !(row && col && ctl.wr) |=> $stable(stored));

endmodule

// File: rtl/rg_array.sv
module rg_array #(
    parameter int ROW_BITS = ramgrid_pkg::DEF_ROW_BITS,
    parameter int COL_BITS = ramgrid_pkg::DEF_COL_BITS,
    parameter int DATA_W   = ramgrid_pkg::DEF_DATA_W,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = 1 << COL_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ROWS-1:0]        row_line,
    input  logic [COLS-1:0]        col_line,
    input  ramgrid_pkg::port_ctl_t ctl,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rbus
);

    localparam int WORDS = ROWS * COLS;

    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                rg_bitcell u_cell (
                    .clk (clk),
                    .rst (rst),
                    .row (row_line[r]),
                    .col (col_line[c]),
                    .ctl (ctl),
                    .d   (wdata[b]),
                    .q   (word_q[r*COLS + c][b])
                );
            end
        end
    end

    // wired-OR read bus: at most one word is selected
    always_comb begin
        rbus = '0;
        for (int w = 0; w < WORDS; w++) rbus |= word_q[w];
    end

endmodule

// File: rtl/ram_grid16x8.sv
module ram_grid16x8 #(
    parameter int ROW_BITS = ramgrid_pkg::DEF_ROW_BITS,
    parameter int COL_BITS = ramgrid_pkg::DEF_COL_BITS,
    parameter int DATA_W   = ramgrid_pkg::DEF_DATA_W,
    localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    logic [ROWS-1:0] row_line;
    logic [COLS-1:0] col_line;
    ramgrid_pkg::port_ctl_t ctl;

    assign ctl = ramgrid_pkg::make_ctl(wr_en, rd_en);

    rg_decoder #(.SEL_BITS(ROW_BITS)) u_row_dec (
        .sel  (addr[ADDR_W-1:COL_BITS]),
        .line (row_line)
    );

    rg_decoder #(.SEL_BITS(COL_BITS)) u_col_dec (
        .sel  (addr[COL_BITS-1:0]),
        .line (col_line)
    );

    rg_array #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .row_line (row_line),
        .col_line (col_line),
        .ctl      (ctl),
        .wdata    (wdata),
        .rbus     (rdata)
    );

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);

    a_r4_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && rd_en && addr == $past(addr))
        |-> rdata == $past(wdata));

    a_r7_reset_empty: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_en) |-> rdata == '0);

endmodule

// File: tb/ram_grid16x8_test.sv
`timescale 1ns/1ps
module ram_grid16x8_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    int model [16];
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ram_grid16x8 uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
    );

    // one cycle: drive after the falling edge, compare mid-low phase,
    // then apply the rising edge to the model
    task automatic step(input bit r, input bit we, input bit re,
                        input int a, input int wd, input string tag);
        int exp;
        @(negedge clk);
        rst = r; wr_en = we; rd_en = re;
        addr = 4'(a); wdata = 8'(wd);
        #1;
        exp = re ? model[a] : 0;
        checks++;
        if (int'(rdata) != exp) begin
            fails++;
            $display("FAIL %s: addr=%0d rdata=%02h expected=%02h", tag, a, rdata, exp);
        end
        @(posedge clk);
        if (r) foreach (model[i]) model[i] = 0;
        else if (we) model[a] = wd & 8'hFF;
    endtask

    initial begin
        foreach (model[i]) model[i] = 0;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        // R7: reset, with a competing write that must lose
        step(1, 0, 0, 0, 0, "R7 reset");
        step(1, 1, 0, 5, 8'hAA, "R7 reset beats write");
        for (int a = 0; a < 16; a++) step(0, 0, 1, a, 0, "R7 empty after reset");

        // R2: write with read gated off shows zero, also the cycle after
        step(0, 1, 0, 3, 8'h5C, "R2 write read-off");
        step(0, 0, 0, 3, 8'h00, "R2 after write read-off");
        step(0, 0, 1, 3, 8'h00, "R3 read written byte");

        // R1 R4 R6: distinct value per location, then read back
        for (int a = 0; a < 16; a++) step(0, 1, 0, a, (a * 37 + 11) & 8'hFF, "R4 fill");
        for (int a = 0; a < 16; a++) step(0, 0, 1, a, 0, "R1 R6 readback");

        // R5: wr_en low with toggling data and address
        for (int a = 0; a < 16; a++) step(0, 0, 1, 15 - a, 8'hFF ^ a, "R5 no write");

        // R9: data changes after the write pulse
        step(0, 1, 0, 9, 8'h96, "R9 write");
        step(0, 0, 1, 9, 8'h00, "R9 hold data low");
        step(0, 0, 1, 9, 8'hFF, "R9 hold data high");

        // R8: read and write same address, old value first
        step(0, 1, 1, 6, 8'h3D, "R8 rw same cycle");
        step(0, 1, 1, 6, 8'hC2, "R8 rw back to back");
        step(0, 0, 1, 6, 8'h00, "R8 new value");
        step(0, 1, 1, 7, 8'h01, "R6 rw other address");
        step(0, 0, 1, 6, 8'h00, "R6 neighbour intact");

        // mixed traffic
        for (int i = 0; i < 200; i++)
            step(0, ((i * 7) % 3) == 0, (i % 4) != 1, (i * 5 + 3) % 16,
                 (i * 73 + 19) & 8'hFF, "R3 R4 mixed");

        // R7: reset mid-run clears contents
        step(1, 0, 1, 2, 0, "R7 reset mid-run");
        for (int a = 0; a < 16; a++) step(0, 0, 1, a, 0, "R7 cleared");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule